// File: doc/BRIEF.md
# Memory-Map Address Decoder

This block sits between a bus master with a 16-bit address bus (8-bit data) and three address regions: a 32K RAM in the lower half of the map, a 16K ROM above it, and a small I/O device that answers at only four locations. It looks at the upper address bits and raises one active-high chip enable for the region that owns the current address. If the address is valid but lands in a gap of the map, it raises an unmapped flag instead.

The regions have uneven sizes and alignments. The RAM is picked by the single top bit. The ROM covers four consecutive values of the top address nibble, a span that does not start on a power-of-two boundary. The I/O device needs fourteen address bits compared. Alongside the enables, the block forwards each region's local offset. The RAM offset is the low 15 bits. The ROM offset is rebased so that its first location reads as zero. The I/O register index is the low two bits. The block has no clock and no state. Each output follows the address and the strobe within the same cycle.

Top module: `mm_addr_decoder`

## Requirements
- R1: `ram_ce_o` is 1 exactly when `valid_i` is 1 and the address lies in 0x0000..0x7FFF (bit 15 clear).
- R2: `rom_ce_o` is 1 exactly when `valid_i` is 1 and address bits 15:12 lie in 4'hB..4'hE inclusive, that is, the address is in 0xB000..0xEFFF.
- R3: `io_ce_o` is 1 exactly when `valid_i` is 1 and address bits 15:2 equal those of 0xF574, that is, the address is in 0xF574..0xF577.
- R4: `unmapped_o` is 1 exactly when `valid_i` is 1 and none of the three regions claims the address. This covers 0x8000..0xAFFF and every 0xFxxx address other than 0xF574..0xF577.
- R5: At most one of `ram_ce_o`, `rom_ce_o`, `io_ce_o`, `unmapped_o` is 1 for any input. All four are 0 whenever `valid_i` is 0, whatever the address.
- R6: `ram_off_o` equals address bits 14:0 for every address.
- R7: `rom_off_o` equals (address − 0xB000) modulo 2^14 for every address, so 0xB000 gives 0 and 0xEFFF gives 0x3FFF.
- R8: `io_idx_o` equals address bits 1:0 for every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 16 | Bus address |
| valid_i | input | 1 | Address strobe; when 0, every select output is 0 |
| ram_ce_o | output | 1 | RAM region enable |
| rom_ce_o | output | 1 | ROM region enable |
| io_ce_o | output | 1 | I/O device enable |
| unmapped_o | output | 1 | Valid address that no region claims |
| ram_off_o | output | 15 | Location inside the RAM |
| rom_off_o | output | 14 | Location inside the ROM, rebased to zero |
| io_idx_o | output | 2 | Register index inside the I/O device |

## Verification
Two functions can be active on the same input: a region hit and strobe gating. Near the I/O window, the I/O hit and the unmapped flag also compete for the same 0xFxxx page. The bench provokes both by sweeping all 65536 addresses twice, once with the strobe high and once with it low. Each address is judged against region bounds computed arithmetically, with the enables expected all zero on the low-strobe pass. On both passes the offsets are checked against the same formulas, because they must not depend on the strobe.

// File: rtl/mm_decode_pkg.sv
package mm_decode_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_RAM  = 2'd1,
        SEL_ROM  = 2'd2,
        SEL_IO   = 2'd3
    } mm_sel_e;

    typedef struct packed {
        logic ram;
        logic rom;
        logic io;
        logic gap;
    } mm_enables_t;

endpackage

// File: rtl/mm_window_match.sv
module mm_window_match #(
    parameter int FIELD_W  = 4,
    parameter bit RANGE_MD = 1'b0,
    parameter int LO       = 0,
    parameter int HI       = 0
) (
    input  logic [FIELD_W-1:0] field_i,
    output logic               hit_o
);
    localparam logic [FIELD_W-1:0] LO_V = FIELD_W'(LO);
    localparam logic [FIELD_W-1:0] HI_V = FIELD_W'(HI);

    generate
        if (RANGE_MD) begin : g_range
            always_comb hit_o = (field_i >= LO_V) && (field_i <= HI_V);
        end else begin : g_exact
            always_comb hit_o = (field_i == LO_V);
        end
    endgenerate
endmodule

// File: rtl/mm_offset_gen.sv
module mm_offset_gen #(
    parameter int RAM_OFF_W = 15,
    parameter int ROM_OFF_W = 14,
    parameter int IO_IDX_W  = 2,
    parameter int ROM_BASE  = 32'hB000
) (
    input  logic [RAM_OFF_W-1:0] low_i,
    output logic [RAM_OFF_W-1:0] ram_off_o,
    output logic [ROM_OFF_W-1:0] rom_off_o,
    output logic [IO_IDX_W-1:0]  io_idx_o
);
    localparam logic [ROM_OFF_W-1:0] ROM_BASE_LOW = ROM_OFF_W'(ROM_BASE);

    always_comb begin
        ram_off_o = low_i;
        rom_off_o = low_i[ROM_OFF_W-1:0] - ROM_BASE_LOW;
        io_idx_o  = low_i[IO_IDX_W-1:0];
    end
endmodule

// File: rtl/mm_addr_decoder.sv
module mm_addr_decoder
    import mm_decode_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int RAM_LOG2  = 15,
    parameter int NIB_W     = 4,
    parameter int ROM_NIB_LO = 4'hB,
    parameter int ROM_NIB_HI = 4'hE,
    parameter int IO_BASE   = 16'hF574,
    parameter int IO_LOG2   = 2,
    localparam int ROM_OFF_W = $clog2(ROM_NIB_HI - ROM_NIB_LO + 1) + (ADDR_W - NIB_W),
    localparam int IO_TAG_W  = ADDR_W - IO_LOG2,
    localparam int RAM_TAG_W = ADDR_W - RAM_LOG2
) (
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 valid_i,
    output logic                 ram_ce_o,
    output logic                 rom_ce_o,
    output logic                 io_ce_o,
    output logic                 unmapped_o,
    output logic [RAM_LOG2-1:0]  ram_off_o,
    output logic [ROM_OFF_W-1:0] rom_off_o,
    output logic [IO_LOG2-1:0]   io_idx_o
);
    localparam int ROM_BASE = ROM_NIB_LO << (ADDR_W - NIB_W);

    logic        ram_hit, rom_hit, io_hit;
    mm_sel_e     sel;
    mm_enables_t en;

    mm_window_match #(.FIELD_W(RAM_TAG_W), .RANGE_MD(1'b0), .LO(0), .HI(0)) u_ram_match (
        .field_i(addr_i[ADDR_W-1 -: RAM_TAG_W]),
        .hit_o  (ram_hit)
    );

    mm_window_match #(.FIELD_W(NIB_W), .RANGE_MD(1'b1), .LO(ROM_NIB_LO), .HI(ROM_NIB_HI)) u_rom_match (
        .field_i(addr_i[ADDR_W-1 -: NIB_W]),
        .hit_o  (rom_hit)
    );

    mm_window_match #(.FIELD_W(IO_TAG_W), .RANGE_MD(1'b0), .LO(IO_BASE >> IO_LOG2), .HI(0)) u_io_match (
        .field_i(addr_i[ADDR_W-1 -: IO_TAG_W]),
        .hit_o  (io_hit)
    );

    // Selection: the smallest window wins, so overlapping parameter sets stay one-hot.
    always_comb begin
        if (!valid_i)     sel = SEL_NONE;
        else if (io_hit)  sel = SEL_IO;
        else if (rom_hit) sel = SEL_ROM;
        else if (ram_hit) sel = SEL_RAM;
        else              sel = SEL_NONE;
    end

    // Output decode of the selection.
    always_comb begin
        en = '0;
        unique case (sel)
            SEL_RAM:  en.ram = 1'b1;
            SEL_ROM:  en.rom = 1'b1;
            SEL_IO:   en.io  = 1'b1;
            SEL_NONE: en.gap = valid_i;
        endcase
    end

    assign ram_ce_o   = en.ram;
    assign rom_ce_o   = en.rom;
    assign io_ce_o    = en.io;
    assign unmapped_o = en.gap;

    mm_offset_gen #(
        .RAM_OFF_W(RAM_LOG2),
        .ROM_OFF_W(ROM_OFF_W),
        .IO_IDX_W (IO_LOG2),
        .ROM_BASE (ROM_BASE)
    ) u_offsets (
        .low_i    (addr_i[RAM_LOG2-1:0]),
        .ram_off_o(ram_off_o),
        .rom_off_o(rom_off_o),
        .io_idx_o (io_idx_o)
    );
endmodule

// File: rtl/mm_addr_decoder_checker.sv
module mm_addr_decoder_checker (
    input logic [15:0] addr_i,
    input logic        valid_i,
    input logic        ram_ce_o,
    input logic        rom_ce_o,
    input logic        io_ce_o,
    input logic        unmapped_o,
    input logic [14:0] ram_off_o,
    input logic [13:0] rom_off_o,
    input logic [1:0]  io_idx_o
);
    always_comb begin
        assert_ram_window_R1: assert (!ram_ce_o || (valid_i && !addr_i[15]));
        assert_rom_window_R2: assert (!rom_ce_o || (valid_i && addr_i >= 16'hB000 && addr_i <= 16'hEFFF));
        assert_io_window_R3: assert (!io_ce_o || (valid_i && addr_i >= 16'hF574 && addr_i <= 16'hF577));
        assert_gap_flag_R4: assert (unmapped_o == (valid_i && !(ram_ce_o || rom_ce_o || io_ce_o)));
        assert_one_select_R5: assert ($countones({ram_ce_o, rom_ce_o, io_ce_o, unmapped_o}) <= 1);
        assert_idle_quiet_R5: assert (valid_i || !(ram_ce_o || rom_ce_o || io_ce_o || unmapped_o));
        assert_ram_offset_R6: assert (ram_off_o == addr_i[14:0]);
        assert_rom_rebase_R7: assert (!rom_ce_o || ({2'b10, rom_off_o} + 16'h3000 == addr_i));
        assert_io_index_R8: assert (io_idx_o == addr_i[1:0]);
    end
endmodule

bind mm_addr_decoder mm_addr_decoder_checker u_checker (
    .addr_i    (addr_i),
    .valid_i   (valid_i),
    .ram_ce_o  (ram_ce_o),
    .rom_ce_o  (rom_ce_o),
    .io_ce_o   (io_ce_o),
    .unmapped_o(unmapped_o),
    .ram_off_o (ram_off_o),
    .rom_off_o (rom_off_o),
    .io_idx_o  (io_idx_o)
);

// File: tb/mm_addr_decoder_test.sv
`timescale 1ns/1ps
module mm_addr_decoder_test;
    logic        clk = 1'b0;
    logic [15:0] addr;
    logic        valid;
    logic        ram_ce, rom_ce, io_ce, gap;
    logic [14:0] ram_off;
    logic [13:0] rom_off;
    logic [1:0]  io_idx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    mm_addr_decoder uut (
        .addr_i    (addr),
        .valid_i   (valid),
        .ram_ce_o  (ram_ce),
        .rom_ce_o  (rom_ce),
        .io_ce_o   (io_ce),
        .unmapped_o(gap),
        .ram_off_o (ram_off),
        .rom_off_o (rom_off),
        .io_idx_o  (io_idx)
    );

    task automatic check_bits(input string tag, input int act, input int exp, input int a);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a[15:0], act, exp);
        end
    endtask

    task automatic probe(input int a, input bit v);
        bit e_ram, e_rom, e_io, e_gap;
        @(negedge clk);
        addr  = a[15:0];
        valid = v;
        @(posedge clk);
        #0.5;
        e_ram = v && (a < 32'h8000);
        e_rom = v && (a >= 32'hB000) && (a <= 32'hEFFF);
        e_io  = v && (a >= 32'hF574) && (a <= 32'hF577);
        e_gap = v && !(e_ram || e_rom || e_io);
        check_bits("R1 ram_ce", int'(ram_ce), int'(e_ram), a);
        check_bits("R2 rom_ce", int'(rom_ce), int'(e_rom), a);
        check_bits("R3 io_ce", int'(io_ce), int'(e_io), a);
        check_bits("R4 unmapped", int'(gap), int'(e_gap), a);
        check_bits("R5 select count", $countones({ram_ce, rom_ce, io_ce, gap}),
                   int'(e_ram) + int'(e_rom) + int'(e_io) + int'(e_gap), a);
        check_bits("R6 ram_off", int'(ram_off), a % 32768, a);
        check_bits("R7 rom_off", int'(rom_off), (a + 65536 - 32'hB000) % 16384, a);
        check_bits("R8 io_idx", int'(io_idx), a % 4, a);
    endtask

    initial begin
        addr  = '0;
        valid = 1'b0;
        @(posedge clk);
        #0.5;
        // R5 idle state: no select with strobe low
        check_bits("R5 idle", int'({ram_ce, rom_ce, io_ce, gap}), 0, 0);
        // Boundary points first
        probe(32'h7FFF, 1'b1);
        probe(32'h8000, 1'b1);
        probe(32'hAFFF, 1'b1);
        probe(32'hB000, 1'b1);
        probe(32'hEFFF, 1'b1);
        probe(32'hF000, 1'b1);
        probe(32'hF573, 1'b1);
        probe(32'hF574, 1'b1);
        probe(32'hF577, 1'b1);
        probe(32'hF578, 1'b1);
        // Full sweeps with strobe high and low
        for (int a = 0; a < 65536; a++) probe(a, 1'b1);
        for (int a = 0; a < 65536; a++) probe(a, 1'b0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 190000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule